// File: doc/BRIEF.md
# Interrupt Controller Command and Status Port

This block is the processor-facing register port of an eight-input programmable interrupt controller. It samples an asynchronous bus (active-low chip select, read strobe and write strobe, one address bit, separate write and read data) into the system clock. It routes every completed write to one of four setup words, to the second or third run-time command word, or to the mask register. It follows the setup sequence that begins with the first setup word and ends with the optional cascade and extension words.

On reads it returns the mask register when the address bit is high. When the address bit is low it returns the pending-request register, the in-service register or the poll word, as chosen by the last third command word. It also drives the enable of the external tri-state data buffer. Priority resolution and the acknowledge cycle live in sibling blocks. This port takes their registers as inputs, hands them its stored words, pulses a strobe for every second command word and reports when a poll read has been consumed.

Top module: `pic_cmd_port`

## Requirements
- R1: A write with address 0 and data bit 4 set stores the first setup word and (re)starts the setup sequence (`init_busy`=1), even in the middle of a sequence. It clears the mask to 00, the third and fourth setup words to 00, returns the read select to the request register and disarms polling.
- R2: After the first setup word, the next address-1 write is setup word 2. Setup word 3 follows only when bit 1 of word 1 is 0 (cascade). Setup word 4 follows only when bit 0 of word 1 is 1. After the last expected word `init_busy` returns to 0.
- R3: An address-1 write while `init_busy`=0 loads the mask register (`mask_q`).
- R4: A write with address 0, data bit 4 = 0 and bit 3 = 0 loads `ocw2_q` and produces exactly one single-cycle pulse on `ocw2_stb`.
- R5: A write with address 0, data bit 4 = 0 and bit 3 = 1 is the third command word. Bits 1:0 = 10 select the request register and 11 the in-service register; 00 or 01 leave the selection unchanged. Bit 2 = 1 arms a poll read.
- R6: A read with address 0 returns the poll word when polling is armed, else the selected register; a read with address 1 returns the mask.
- R7: The end of an address-0 read with polling armed disarms it and pulses `poll_taken` once; an address-1 read leaves it armed.
- R8: `data_oe` = `ack_bus_en` OR (`cs_n`=0 AND `rd_n`=0 AND `wr_n`=1); chip select does not gate `ack_bus_en`.
- R9: A write during which `rd_n` was also low is ignored.
- R10: A write strobe while `cs_n` is high is ignored.
- R11: After reset: `mask_q`=FF, all setup words and `ocw2_q` 00, `init_busy`=0, `ocw2_stb`=0, request register selected, polling disarmed.
- R12: A write takes effect only after the rising edge of `wr_n`: registers hold while it is low, and the effect shows within SYNC_STAGES+2 clock cycles of the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Address bit |
| wdata | input | 8 | Write data from the bus |
| ack_bus_en | input | 1 | Acknowledge logic is driving the bus |
| irr | input | 8 | Pending-request register |
| isr | input | 8 | In-service register |
| poll_word | input | 8 | Poll result from the priority logic |
| rdata | output | 8 | Read data toward the bus buffer |
| data_oe | output | 1 | Tri-state buffer enable |
| mask_q | output | 8 | Mask register |
| icw1_q | output | 8 | Setup word 1 |
| icw2_q | output | 8 | Setup word 2 |
| icw3_q | output | 8 | Setup word 3 |
| icw4_q | output | 8 | Setup word 4 |
| ocw2_q | output | 8 | Last second command word |
| ocw2_stb | output | 1 | One-cycle pulse per second command word |
| init_busy | output | 1 | Setup sequence in progress |
| poll_taken | output | 1 | One-cycle pulse when a poll read completes |

## Verification
On every cycle, assertions check several properties. The mask changes only on a committed write. The command strobe never lasts two cycles. A commit always follows a sampled low write strobe. The final setup word returns the sequencer to normal operation. A completed poll read leaves polling disarmed. The bench scenarios are needed for the rest: the routing of each data pattern to the right word across all four setup variants, the read-select and poll interplay as seen on `rdata`, that clashing or deselected strobes are ignored, and the cycle at which a write becomes visible.

// File: rtl/pic_port_pkg.sv
package pic_port_pkg;
   localparam int unsigned DATA_W = 8;

   // bit positions decoded by this port
   localparam int unsigned B_START   = 4;  // address 0: first setup word
   localparam int unsigned B_CMD3    = 3;  // address 0: third command word
   localparam int unsigned B_SINGLE  = 1;  // setup word 1: no cascade
   localparam int unsigned B_NEED4   = 0;  // setup word 1: fourth word follows
   localparam int unsigned B_POLL    = 2;  // command 3: arm poll
   localparam int unsigned B_SELVAL  = 1;  // command 3: selection valid
   localparam int unsigned B_SELISR  = 0;  // command 3: in-service chosen

   typedef enum logic [1:0] {
      SEQ_READY = 2'd0,
      SEQ_W2    = 2'd1,
      SEQ_W3    = 2'd2,
      SEQ_W4    = 2'd3
   } seq_t;

   typedef enum logic [2:0] {
      CMD_ICW1 = 3'd0,
      CMD_ICW2 = 3'd1,
      CMD_ICW3 = 3'd2,
      CMD_ICW4 = 3'd3,
      CMD_MASK = 3'd4,
      CMD_OCW2 = 3'd5,
      CMD_OCW3 = 3'd6
   } cmd_t;

   typedef struct packed {
      logic              a0;
      logic [DATA_W-1:0] data;
   } bus_cap_t;

   function automatic cmd_t classify(input logic a0, input logic [DATA_W-1:0] d,
                                     input seq_t seq);
      cmd_t c;
      if (!a0) begin
         if (d[B_START])     c = CMD_ICW1;
         else if (d[B_CMD3]) c = CMD_OCW3;
         else                c = CMD_OCW2;
      end else begin
         case (seq)
            SEQ_W2:  c = CMD_ICW2;
            SEQ_W3:  c = CMD_ICW3;
            SEQ_W4:  c = CMD_ICW4;
            default: c = CMD_MASK;
         endcase
      end
      return c;
   endfunction
endpackage

// File: rtl/pic_strobe_sync.sv
module pic_strobe_sync
   import pic_port_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              a0,
   input  logic [DATA_W-1:0] wdata,
   output logic              wr_commit,
   output bus_cap_t          wr_cap,
   output logic              rd_end_lo
);
   localparam int unsigned LANE_W = 4 + DATA_W;
   localparam logic [LANE_W-1:0] IDLE_LANE = {3'b111, {(LANE_W-3){1'b0}}};

   logic [STAGES-1:0][LANE_W-1:0] lane;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) lane[i] <= IDLE_LANE;
      end else begin
         lane[0] <= {cs_n, rd_n, wr_n, a0, wdata};
         for (int i = 1; i < int'(STAGES); i++) lane[i] <= lane[i-1];
      end
   end

   logic              s_cs, s_rd, s_wr, s_a0;
   logic [DATA_W-1:0] s_data;
   assign s_cs   = lane[STAGES-1][LANE_W-1];
   assign s_rd   = lane[STAGES-1][LANE_W-2];
   assign s_wr   = lane[STAGES-1][LANE_W-3];
   assign s_a0   = lane[STAGES-1][DATA_W];
   assign s_data = lane[STAGES-1][DATA_W-1:0];

   logic wr_prev, rd_prev;
   logic wsel, wclash, rsel, rlo, rclash;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev <= 1'b1;
         rd_prev <= 1'b1;
         wsel    <= 1'b0;
         wclash  <= 1'b0;
         wr_cap  <= '0;
         rsel    <= 1'b0;
         rlo     <= 1'b0;
         rclash  <= 1'b0;
      end else begin
         wr_prev <= s_wr;
         rd_prev <= s_rd;
         if (!s_wr) begin
            if (!s_cs) begin
               wsel   <= 1'b1;
               wr_cap <= '{a0: s_a0, data: s_data};
            end
            if (!s_rd) wclash <= 1'b1;
         end else if (!wr_prev) begin
            wsel   <= 1'b0;
            wclash <= 1'b0;
         end
         if (!s_rd) begin
            if (!s_cs) begin
               rsel <= 1'b1;
               rlo  <= !s_a0;
            end
            if (!s_wr) rclash <= 1'b1;
         end else if (!rd_prev) begin
            rsel   <= 1'b0;
            rclash <= 1'b0;
         end
      end
   end

   assign wr_commit = s_wr && !wr_prev && wsel && !wclash;
   assign rd_end_lo = s_rd && !rd_prev && rsel && rlo && !rclash;

   // R12: a commit is always preceded by a sampled low write strobe
   a_r12_commit_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> !$past(s_wr));
endmodule

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
   import pic_port_pkg::*;
#(
   parameter logic [DATA_W-1:0] MASK_RESET = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_commit,
   input  bus_cap_t          wr_cap,
   input  logic              poll_clr,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] icw1_q,
   output logic [DATA_W-1:0] icw2_q,
   output logic [DATA_W-1:0] icw3_q,
   output logic [DATA_W-1:0] icw4_q,
   output logic [DATA_W-1:0] ocw2_q,
   output logic              ocw2_stb,
   output logic              sel_isr,
   output logic              poll_arm,
   output logic              init_busy
);
   seq_t seq_q;
   cmd_t cmd;
   logic [DATA_W-1:0] d;

   assign d   = wr_cap.data;
   assign cmd = classify(wr_cap.a0, d, seq_q);

   function automatic seq_t after_w2(input logic [DATA_W-1:0] w1);
      if (!w1[B_SINGLE])   return SEQ_W3;
      else if (w1[B_NEED4]) return SEQ_W4;
      else                  return SEQ_READY;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q    <= SEQ_READY;
         mask_q   <= MASK_RESET;
         icw1_q   <= '0;
         icw2_q   <= '0;
         icw3_q   <= '0;
         icw4_q   <= '0;
         ocw2_q   <= '0;
         ocw2_stb <= 1'b0;
         sel_isr  <= 1'b0;
         poll_arm <= 1'b0;
      end else begin
         ocw2_stb <= 1'b0;
         if (poll_clr) poll_arm <= 1'b0;
         if (wr_commit) begin
            unique case (cmd)
               CMD_ICW1: begin
                  icw1_q   <= d;
                  icw3_q   <= '0;
                  icw4_q   <= '0;
                  mask_q   <= '0;
                  sel_isr  <= 1'b0;
                  poll_arm <= 1'b0;
                  seq_q    <= SEQ_W2;
               end
               CMD_ICW2: begin
                  icw2_q <= d;
                  seq_q  <= after_w2(icw1_q);
               end
               CMD_ICW3: begin
                  icw3_q <= d;
                  seq_q  <= icw1_q[B_NEED4] ? SEQ_W4 : SEQ_READY;
               end
               CMD_ICW4: begin
                  icw4_q <= d;
                  seq_q  <= SEQ_READY;
               end
               CMD_MASK: mask_q <= d;
               CMD_OCW2: begin
                  ocw2_q   <= d;
                  ocw2_stb <= 1'b1;
               end
               CMD_OCW3: begin
                  if (d[B_SELVAL]) sel_isr <= d[B_SELISR];
                  if (d[B_POLL])   poll_arm <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   assign init_busy = (seq_q != SEQ_READY);

   // R3: the mask moves only on a committed write
   a_r3_mask_write_only: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_commit |=> $stable(mask_q));
   // R4: the command strobe never lasts two cycles
   a_r4_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
      ocw2_stb |=> !ocw2_stb);
   // R2: the final setup word returns the sequencer to normal operation
   a_r2_w4_ends_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit && wr_cap.a0 && seq_q == SEQ_W4) |=> !init_busy);
   // R1: a start word always opens a sequence
   a_r1_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit && !wr_cap.a0 && wr_cap.data[B_START]) |=> (init_busy && mask_q == '0));
endmodule

// File: rtl/pic_read_mux.sv
module pic_read_mux
   import pic_port_pkg::*;
(
   input  logic              a0,
   input  logic              sel_isr,
   input  logic              poll_arm,
   input  logic [DATA_W-1:0] irr,
   input  logic [DATA_W-1:0] isr,
   input  logic [DATA_W-1:0] poll_word,
   input  logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      if (a0)            rdata = mask_q;
      else if (poll_arm) rdata = poll_word;
      else if (sel_isr)  rdata = isr;
      else               rdata = irr;
   end
endmodule

// File: rtl/pic_cmd_port.sv
module pic_cmd_port
   import pic_port_pkg::*;
#(
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [DATA_W-1:0] MASK_RESET  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              a0,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ack_bus_en,
   input  logic [DATA_W-1:0] irr,
   input  logic [DATA_W-1:0] isr,
   input  logic [DATA_W-1:0] poll_word,
   output logic [DATA_W-1:0] rdata,
   output logic              data_oe,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] icw1_q,
   output logic [DATA_W-1:0] icw2_q,
   output logic [DATA_W-1:0] icw3_q,
   output logic [DATA_W-1:0] icw4_q,
   output logic [DATA_W-1:0] ocw2_q,
   output logic              ocw2_stb,
   output logic              init_busy,
   output logic              poll_taken
);
   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_stages
         $error("SYNC_STAGES must lie in 1..4");
      end
      if (DATA_W <= B_START) begin : g_bad_width
         $error("data width too narrow for command decode");
      end
   endgenerate

   logic     wr_commit, rd_end_lo, sel_isr, poll_arm;
   bus_cap_t wr_cap;

   pic_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .a0(a0), .wdata(wdata), .wr_commit(wr_commit), .wr_cap(wr_cap),
      .rd_end_lo(rd_end_lo)
   );

   assign poll_taken = rd_end_lo && poll_arm;

   pic_cmd_decode #(.MASK_RESET(MASK_RESET)) dec_i (
      .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .wr_cap(wr_cap),
      .poll_clr(poll_taken), .mask_q(mask_q), .icw1_q(icw1_q),
      .icw2_q(icw2_q), .icw3_q(icw3_q), .icw4_q(icw4_q), .ocw2_q(ocw2_q),
      .ocw2_stb(ocw2_stb), .sel_isr(sel_isr), .poll_arm(poll_arm),
      .init_busy(init_busy)
   );

   pic_read_mux mux_i (
      .a0(a0), .sel_isr(sel_isr), .poll_arm(poll_arm), .irr(irr), .isr(isr),
      .poll_word(poll_word), .mask_q(mask_q), .rdata(rdata)
   );

   assign data_oe = ack_bus_en || (!cs_n && !rd_n && wr_n);

   // R7: a completed poll read leaves polling disarmed
   a_r7_poll_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_taken && !wr_commit) |=> !poll_arm);
   // R7: the poll pulse is single-cycle
   a_r7_poll_single: assert property (@(posedge clk) disable iff (!rst_n)
      poll_taken |=> !poll_taken);
endmodule

// File: tb/pic_cmd_port_tb_top.sv
module pic_cmd_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0, ack_bus_en = 1'b0;
   logic [7:0] wdata = '0, irr = 8'hA5, isr = 8'h3C, poll_word = 8'h83;
   logic [7:0] rdata, mask_q, icw1_q, icw2_q, icw3_q, icw4_q, ocw2_q;
   logic       data_oe, ocw2_stb, init_busy, poll_taken;

   int n_chk = 0, n_fail = 0, stb_cnt = 0, poll_cnt = 0;
   bit done = 0;

   always #5 clk = ~clk;

   pic_cmd_port dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
      .wdata(wdata), .ack_bus_en(ack_bus_en), .irr(irr), .isr(isr),
      .poll_word(poll_word), .rdata(rdata), .data_oe(data_oe), .mask_q(mask_q),
      .icw1_q(icw1_q), .icw2_q(icw2_q), .icw3_q(icw3_q), .icw4_q(icw4_q),
      .ocw2_q(ocw2_q), .ocw2_stb(ocw2_stb), .init_busy(init_busy),
      .poll_taken(poll_taken)
   );

   always @(negedge clk) begin
      if (ocw2_stb) stb_cnt++;
      if (poll_taken) poll_cnt++;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic wr_cyc(input logic a, input logic [7:0] d,
                         input logic sel = 1'b1, input logic clash = 1'b0);
      @(negedge clk);
      cs_n = !sel; a0 = a; wdata = d; wr_n = 1'b0; rd_n = !clash;
      repeat (4) @(negedge clk);
      wr_n = 1'b1; rd_n = 1'b1;
      repeat (6) @(negedge clk);
      cs_n = 1'b1;
   endtask

   task automatic rd_cyc(input logic a, output logic [7:0] v, output logic oe);
      @(negedge clk);
      cs_n = 1'b0; a0 = a; rd_n = 1'b0;
      repeat (3) @(negedge clk);
      v = rdata; oe = data_oe;
      rd_n = 1'b1;
      repeat (6) @(negedge clk);
      cs_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual expired expected finish");
      report();
   end

   initial begin
      logic [7:0] v, m;
      logic oe;
      logic sel_model;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R11 reset state
      chk("R11 mask", mask_q, 8'hFF);
      chk("R11 busy", init_busy, 0);
      chk("R11 icw1", icw1_q, 0);
      chk("R11 icw2", icw2_q, 0);
      chk("R11 icw3", icw3_q, 0);
      chk("R11 icw4", icw4_q, 0);
      chk("R11 ocw2", ocw2_q, 0);
      chk("R11 stb", ocw2_stb, 0);
      rd_cyc(1'b0, v, oe);
      chk("R11 select request reg", v, 8'hA5);
      chk("R11 no poll", poll_cnt, 0);

      // R1 R2 every setup variant
      for (int k = 0; k < 4; k++) begin
         logic [7:0] w1;
         w1 = 8'h10 | 8'(k);
         wr_cyc(1'b1, 8'h33);
         chk("R3 mask before start", mask_q, 8'h33);
         wr_cyc(1'b0, w1);
         chk("R1 busy", init_busy, 1);
         chk("R1 icw1", icw1_q, w1);
         chk("R1 mask cleared", mask_q, 0);
         wr_cyc(1'b1, 8'h40 + 8'(k));
         chk("R2 icw2", icw2_q, 8'h40 + k);
         if (!w1[1]) begin
            chk("R2 busy before w3", init_busy, 1);
            wr_cyc(1'b1, 8'h80 + 8'(k));
            chk("R2 icw3", icw3_q, 8'h80 + k);
         end else chk("R2 icw3 skipped", icw3_q, 0);
         if (w1[0]) begin
            chk("R2 busy before w4", init_busy, 1);
            wr_cyc(1'b1, 8'h01 + 8'(k));
            chk("R2 icw4", icw4_q, 1 + k);
         end else chk("R2 icw4 skipped", icw4_q, 0);
         chk("R2 sequence done", init_busy, 0);
         chk("R2 mask untouched", mask_q, 0);
      end

      // R1 restart in mid-sequence
      wr_cyc(1'b0, 8'h10);
      wr_cyc(1'b1, 8'h21);
      chk("R1 mid busy", init_busy, 1);
      wr_cyc(1'b0, 8'h13);
      wr_cyc(1'b1, 8'h77);
      chk("R1 restart routes to icw2", icw2_q, 8'h77);
      chk("R1 restart icw3 kept clear", icw3_q, 0);
      wr_cyc(1'b1, 8'h05);
      chk("R1 restart icw4", icw4_q, 8'h05);
      chk("R1 restart done", init_busy, 0);

      // R3 R6 exhaustive mask sweep
      for (int mv = 0; mv < 256; mv++) begin
         wr_cyc(1'b1, 8'(mv));
         chk("R3 mask_q", mask_q, mv);
         rd_cyc(1'b1, v, oe);
         chk("R6 mask read", v, mv);
      end

      // R4 every second-command pattern
      for (int dv = 0; dv < 256; dv++) begin
         if (dv[4:3] == 2'b00) begin
            stb_cnt = 0;
            wr_cyc(1'b0, 8'(dv));
            chk("R4 ocw2", ocw2_q, dv);
            chk("R4 one pulse", stb_cnt, 1);
         end
      end

      // R5 R6 read select
      sel_model = 1'b0;
      for (int rep = 0; rep < 2; rep++) begin
         for (int rs = 0; rs < 4; rs++) begin
            wr_cyc(1'b0, 8'h08 | 8'(rs));
            if (rs[1]) sel_model = rs[0];
            rd_cyc(1'b0, v, oe);
            chk("R5 R6 selected reg", v, sel_model ? 8'h3C : 8'hA5);
            chk("R8 read oe", oe, 1);
         end
      end
      // ends with in-service selected

      // R7 poll
      poll_cnt = 0;
      wr_cyc(1'b0, 8'h0C);
      rd_cyc(1'b1, v, oe);
      chk("R7 addr1 read is mask", v, 8'hFF);
      chk("R7 addr1 no poll pulse", poll_cnt, 0);
      rd_cyc(1'b0, v, oe);
      chk("R6 poll word", v, 8'h83);
      chk("R7 poll pulse", poll_cnt, 1);
      rd_cyc(1'b0, v, oe);
      chk("R7 back to selection", v, 8'h3C);
      chk("R7 single pulse", poll_cnt, 1);

      // R8 buffer enable, all pin combinations
      a0 = 1'b1; wdata = mask_q;
      for (int c = 0; c < 16; c++) begin
         @(negedge clk);
         {ack_bus_en, cs_n, rd_n, wr_n} = 4'(c);
         @(negedge clk);
         chk("R8 data_oe", data_oe, c[3] | (!c[2] & !c[1] & c[0]));
         ack_bus_en = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
         repeat (6) @(negedge clk);
      end

      // R9 clashing strobes
      m = mask_q;
      wr_cyc(1'b1, ~m, 1'b1, 1'b1);
      chk("R9 mask unchanged", mask_q, m);
      stb_cnt = 0;
      wr_cyc(1'b0, 8'h07, 1'b1, 1'b1);
      chk("R9 no strobe", stb_cnt, 0);
      chk("R9 ocw2 unchanged", ocw2_q, 8'hE7);

      // R10 deselected writes
      wr_cyc(1'b1, 8'h5E, 1'b0);
      chk("R10 mask unchanged", mask_q, m);
      wr_cyc(1'b0, 8'h1F, 1'b0);
      chk("R10 no start", init_busy, 0);

      // R12 write timing
      @(negedge clk);
      cs_n = 1'b0; a0 = 1'b1; wdata = 8'h6D; wr_n = 1'b0;
      repeat (8) @(negedge clk);
      chk("R12 hold while low", mask_q, m);
      wr_n = 1'b1;
      @(negedge clk);
      chk("R12 not yet", mask_q, m);
      repeat (4) @(negedge clk);
      chk("R12 applied", mask_q, 8'h6D);
      cs_n = 1'b1;

      report();
   end
endmodule